// File: doc/BRIEF.md
# Interrupt Vectoring and Call Frame Sequencer

This block owns the program counter and the program status byte of a small 8-bit controller. It carries out subroutine calls and returns, and it turns pending external or timer interrupt requests into forced calls to fixed vector addresses. The program counter is 12 bits wide: bit 11 is the bank bit and bits 10:0 are the in-bank address.

A call or an interrupt entry pushes a two-byte return frame into a RAM that lives outside the block. The frame slot is chosen by a 3-bit stack pointer held in the low bits of the status byte. A return reads the frame back and unwinds it. While an interrupt service routine runs, a mask keeps any further interrupt entry out until the next return completes.

The surrounding core issues one-cycle commands: call, return, program counter step, or status byte write. It issues a command only while `busy` is low. The block also maps a working-register number to its RAM address, using the bank-select bit of the status byte.

Top module: `ivf_frame_unit`

## Requirements
- R1: After reset, `pc` is 0, `psw` is 0, `irq_mask` is 0 and `busy` is 0.
- R2: A push writes exactly two RAM bytes on two consecutive cycles: the first at address 8 + 2*SP and the second at address 9 + 2*SP, where SP is `psw[2:0]` before the push.
- R3: The first frame byte is return-address bits 7:0. The second frame byte is `{psw[7:4], 1'b0, return-address[10:8]}`.
- R4: When a push completes, `psw[2:0]` becomes SP+1 modulo 8, and `psw[7:3]` is unchanged.
- R5: A call jumps to `{bank_bit, call_page, call_imm}` and saves the return address `pc[10:0] + 2`, taken modulo 2^11.
- R6: A pending external request is served before a pending timer request. The external vector is `{bank_bit, 11'd3}` and the timer vector is `{bank_bit, 11'd7}`.
- R7: Taking an interrupt sets `irq_mask`. While `irq_mask` is 1, no interrupt is taken. Only the pending bit of the request that was taken is cleared.
- R8: An interrupt entry saves the current `pc[10:0]` (the next instruction to execute) as the return address. No increment is added.
- R9: A step adds `step_len` (0 to 3) to `pc[10:0]` modulo 2^11 and never changes `pc[11]`.
- R10: `reg_addr` equals `reg_sel` when `psw[4]` is 0, and 24 + `reg_sel` when `psw[4]` is 1.
- R11: A return reads the frame at SP-1 (modulo 8). It restores `pc[10:0]` from that frame, keeps `pc[11]`, sets `psw[2:0]` to SP-1 modulo 8, clears `irq_mask`, and writes nothing to RAM.
- R12: `busy` is 1 in every cycle where an interrupt is being taken or a push or pop is in progress. Any command presented in such a cycle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_req | input | 1 | External interrupt request; sets the external pending bit while high |
| tmr_req | input | 1 | Timer interrupt request; sets the timer pending bit while high |
| call_go | input | 1 | Call command |
| ret_go | input | 1 | Return command |
| call_page | input | 3 | Call target bits 10:8 |
| call_imm | input | 8 | Call target bits 7:0 |
| bank_bit | input | 1 | Bank bit used as target bit 11 for calls and vectors |
| step_go | input | 1 | Program counter step command |
| step_len | input | 2 | Step size |
| psw_we | input | 1 | Status byte write command |
| psw_wdata | input | 8 | Status byte write value |
| reg_sel | input | 3 | Working register number |
| busy | output | 1 | Commands are ignored while high |
| pc | output | 12 | Program counter |
| psw | output | 8 | Status byte; bits 2:0 are the stack pointer |
| irq_mask | output | 1 | Interrupt service in progress |
| reg_addr | output | 8 | RAM address of the selected working register |
| ram_we | output | 1 | RAM write strobe |
| ram_addr | output | 8 | RAM address |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data, combinational from `ram_addr` |

## Verification
Eight calls are made in a row from stack pointer 0, with the upper status nibble changed between calls. This makes the stack pointer wrap from 7 to 0, and it shows whether each frame's address and status bits are computed for that slot and not copied from a neighbouring slot. Eight returns then unwind the stack through the 0-to-7 underflow. Each return must land on the matching saved address, which catches errors in frame order or byte order. Interrupt tests use an external request alone, a timer request raised while masked, and both requests together; these separate priority order, mask behaviour and the clearing of each pending bit. Program counter steps taken across the end of the bank, and presenting commands while `busy` is high, show that bit 11 is kept and that commands in a busy cycle are ignored.

// File: rtl/ivf_pkg.sv
package ivf_pkg;
  localparam int PC_W  = 12;
  localparam int LOW_W = PC_W - 1;
  localparam int DW    = 8;
  localparam int SP_W  = 3;
  localparam int AW    = 8;
  localparam logic [AW-1:0]    FRAME_BASE = 8'd8;
  localparam logic [AW-1:0]    BANK1_BASE = 8'd24;
  localparam logic [LOW_W-1:0] VEC_EXT    = 11'd3;
  localparam logic [LOW_W-1:0] VEC_TMR    = 11'd7;

  typedef enum logic [1:0] {SQ_IDLE = 2'd0, SQ_PUSH2 = 2'd1, SQ_POP2 = 2'd2} sq_e;

  // Address of byte 0 (hi=0) or byte 1 (hi=1) of frame slot sp
  function automatic logic [AW-1:0] frame_addr(input logic [SP_W-1:0] sp, input logic hi);
    return FRAME_BASE + {{(AW-SP_W-1){1'b0}}, sp, hi};
  endfunction

  // Second frame byte: upper status nibble plus return bits 10:8
  function automatic logic [DW-1:0] frame_hi(input logic [DW-1:0] st, input logic [2:0] rhi);
    return {st[7:4], 1'b0, rhi};
  endfunction

  function automatic logic [PC_W-1:0] call_target(input logic bank, input logic [2:0] page,
                                                   input logic [7:0] imm);
    return {bank, page, imm};
  endfunction

  function automatic logic [PC_W-1:0] pc_advance(input logic [PC_W-1:0] p, input logic [1:0] n);
    return {p[PC_W-1], p[LOW_W-1:0] + {{(LOW_W-2){1'b0}}, n}};
  endfunction

  function automatic logic [AW-1:0] bank_reg_addr(input logic sel_hi, input logic [2:0] r);
    return (sel_hi ? BANK1_BASE : '0) + {{(AW-3){1'b0}}, r};
  endfunction

  function automatic logic [PC_W-1:0] vector_addr(input logic bank, input logic is_tmr);
    return {bank, is_tmr ? VEC_TMR : VEC_EXT};
  endfunction
endpackage

// File: rtl/ivf_arbiter.sv
module ivf_arbiter (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_req,
  input  logic tmr_req,
  input  logic seq_idle,
  input  logic pop_done,
  output logic take_ext,
  output logic take_tmr,
  output logic ext_pend,
  output logic irq_mask
);
  logic tmr_pend;

  assign take_ext = seq_idle & ~irq_mask & ext_pend;
  assign take_tmr = seq_idle & ~irq_mask & ~ext_pend & tmr_pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ext_pend <= 1'b0;
      tmr_pend <= 1'b0;
      irq_mask <= 1'b0;
    end else begin
      ext_pend <= (ext_pend & ~take_ext) | ext_req;
      tmr_pend <= (tmr_pend & ~take_tmr) | tmr_req;
      if (take_ext | take_tmr) irq_mask <= 1'b1;
      else if (pop_done)       irq_mask <= 1'b0;
    end
  end
endmodule

// File: rtl/ivf_seq.sv
module ivf_seq
  import ivf_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               push_go,
  input  logic               pop_go,
  input  logic [LOW_W-1:0]   push_ret,
  input  logic [PC_W-1:0]    push_tgt,
  input  logic [DW-1:0]      psw,
  input  logic [DW-1:0]      ram_rdata,
  output logic               seq_idle,
  output logic               push_done,
  output logic               pop_done,
  output logic [PC_W-1:0]    tgt_q,
  output logic [LOW_W-1:0]   pop_low,
  output logic               ram_we,
  output logic [AW-1:0]      ram_addr,
  output logic [DW-1:0]      ram_wdata
);
  sq_e             state;
  logic [2:0]      ret_hi_q;
  logic [DW-1:0]   lo_q;
  logic [SP_W-1:0] sp, sp_dn;

  assign sp        = psw[SP_W-1:0];
  assign sp_dn     = sp - 3'd1;
  assign seq_idle  = (state == SQ_IDLE);
  assign push_done = (state == SQ_PUSH2);
  assign pop_done  = (state == SQ_POP2);
  assign pop_low   = {ram_rdata[2:0], lo_q};

  always_comb begin
    ram_we    = 1'b0;
    ram_addr  = frame_addr(sp, 1'b0);
    ram_wdata = push_ret[7:0];
    unique case (state)
      SQ_IDLE: begin
        if (push_go)     ram_we = 1'b1;
        else if (pop_go) ram_addr = frame_addr(sp_dn, 1'b0);
      end
      SQ_PUSH2: begin
        ram_we    = 1'b1;
        ram_addr  = frame_addr(sp, 1'b1);
        ram_wdata = frame_hi(psw, ret_hi_q);
      end
      SQ_POP2:  ram_addr = frame_addr(sp_dn, 1'b1);
      default:  ram_addr = frame_addr(sp, 1'b0);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= SQ_IDLE;
      ret_hi_q <= '0;
      lo_q     <= '0;
      tgt_q    <= '0;
    end else begin
      unique case (state)
        SQ_IDLE: begin
          if (push_go) begin
            state    <= SQ_PUSH2;
            ret_hi_q <= push_ret[LOW_W-1:8];
            tgt_q    <= push_tgt;
          end else if (pop_go) begin
            state <= SQ_POP2;
            lo_q  <= ram_rdata;
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ivf_regs.sv
module ivf_regs
  import ivf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_done,
  input  logic [PC_W-1:0]  tgt_q,
  input  logic             pop_done,
  input  logic [LOW_W-1:0] pop_low,
  input  logic             step_fire,
  input  logic [1:0]       step_len,
  input  logic             psw_fire,
  input  logic [DW-1:0]    psw_wdata,
  output logic [PC_W-1:0]  pc,
  output logic [DW-1:0]    psw
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc  <= '0;
      psw <= '0;
    end else if (push_done) begin
      pc            <= tgt_q;
      psw[SP_W-1:0] <= psw[SP_W-1:0] + 3'd1;
    end else if (pop_done) begin
      pc[LOW_W-1:0] <= pop_low;
      psw[SP_W-1:0] <= psw[SP_W-1:0] - 3'd1;
    end else if (step_fire) begin
      pc <= pc_advance(pc, step_len);
    end else if (psw_fire) begin
      psw <= psw_wdata;
    end
  end
endmodule

// File: rtl/ivf_frame_unit.sv
module ivf_frame_unit
  import ivf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_req,
  input  logic             tmr_req,
  input  logic             call_go,
  input  logic             ret_go,
  input  logic [2:0]       call_page,
  input  logic [7:0]       call_imm,
  input  logic             bank_bit,
  input  logic             step_go,
  input  logic [1:0]       step_len,
  input  logic             psw_we,
  input  logic [DW-1:0]    psw_wdata,
  input  logic [2:0]       reg_sel,
  output logic             busy,
  output logic [PC_W-1:0]  pc,
  output logic [DW-1:0]    psw,
  output logic             irq_mask,
  output logic [AW-1:0]    reg_addr,
  output logic             ram_we,
  output logic [AW-1:0]    ram_addr,
  output logic [DW-1:0]    ram_wdata,
  input  logic [DW-1:0]    ram_rdata
);
  logic take_ext, take_tmr, take, ext_pend;
  logic seq_idle, push_done, pop_done;
  logic cmd_ok, call_fire, ret_fire, step_fire, psw_fire, push_go;
  logic [PC_W-1:0]  push_tgt, tgt_q, call_ret_full;
  logic [LOW_W-1:0] push_ret, pop_low;

  assign take      = take_ext | take_tmr;
  assign busy      = ~seq_idle | take;
  assign cmd_ok    = seq_idle & ~take;
  assign call_fire = cmd_ok & call_go;
  assign ret_fire  = cmd_ok & ~call_go & ret_go;
  assign step_fire = cmd_ok & ~call_go & ~ret_go & step_go;
  assign psw_fire  = cmd_ok & ~call_go & ~ret_go & ~step_go & psw_we;
  assign push_go   = take | call_fire;

  assign call_ret_full = pc_advance(pc, 2'd2);
  assign push_ret  = take ? pc[LOW_W-1:0] : call_ret_full[LOW_W-1:0];
  assign push_tgt  = take ? vector_addr(bank_bit, take_tmr)
                          : call_target(bank_bit, call_page, call_imm);
  assign reg_addr  = bank_reg_addr(psw[4], reg_sel);

  ivf_arbiter u_arb (
    .clk(clk), .rst_n(rst_n), .ext_req(ext_req), .tmr_req(tmr_req),
    .seq_idle(seq_idle), .pop_done(pop_done),
    .take_ext(take_ext), .take_tmr(take_tmr), .ext_pend(ext_pend), .irq_mask(irq_mask)
  );

  ivf_seq u_seq (
    .clk(clk), .rst_n(rst_n), .push_go(push_go), .pop_go(ret_fire),
    .push_ret(push_ret), .push_tgt(push_tgt), .psw(psw), .ram_rdata(ram_rdata),
    .seq_idle(seq_idle), .push_done(push_done), .pop_done(pop_done),
    .tgt_q(tgt_q), .pop_low(pop_low),
    .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata)
  );

  ivf_regs u_regs (
    .clk(clk), .rst_n(rst_n), .push_done(push_done), .tgt_q(tgt_q),
    .pop_done(pop_done), .pop_low(pop_low), .step_fire(step_fire),
    .step_len(step_len), .psw_fire(psw_fire), .psw_wdata(psw_wdata),
    .pc(pc), .psw(psw)
  );
endmodule

// File: rtl/ivf_frame_chk.sv
module ivf_frame_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        take_ext,
  input logic        take_tmr,
  input logic        ext_pend,
  input logic        irq_mask,
  input logic        push_done,
  input logic        pop_done,
  input logic        step_fire,
  input logic        ram_we,
  input logic [7:0]  ram_addr,
  input logic [7:0]  psw,
  input logic [11:0] pc
);
  AST_FRAME_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ram_we) |=> ram_we && (ram_addr == $past(ram_addr) + 8'd1)); // R2
  AST_SP_INC: assert property (@(posedge clk) disable iff (!rst_n)
    push_done |=> psw[2:0] == $past(psw[2:0]) + 3'd1); // R4
  AST_PSW_HI_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    push_done |=> psw[7:3] == $past(psw[7:3])); // R4
  AST_ONE_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({take_ext, take_tmr})); // R6
  AST_EXT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    take_tmr |-> !ext_pend); // R6
  AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    irq_mask |-> !(take_ext || take_tmr)); // R7
  AST_TAKE_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
    (take_ext || take_tmr) |=> irq_mask); // R7
  AST_STEP_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    step_fire |=> pc[11] == $past(pc[11])); // R9
  AST_RET_UNMASK: assert property (@(posedge clk) disable iff (!rst_n)
    pop_done |=> !irq_mask); // R11
  AST_SP_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    pop_done |=> psw[2:0] == $past(psw[2:0]) - 3'd1); // R11
  AST_POP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    pop_done |-> !ram_we); // R11
endmodule

bind ivf_frame_unit ivf_frame_chk u_chk (
  .clk(clk), .rst_n(rst_n), .take_ext(take_ext), .take_tmr(take_tmr),
  .ext_pend(ext_pend), .irq_mask(irq_mask), .push_done(push_done),
  .pop_done(pop_done), .step_fire(step_fire), .ram_we(ram_we),
  .ram_addr(ram_addr), .psw(psw), .pc(pc)
);

// File: tb/ivf_frame_unit_bench.sv
module ivf_frame_unit_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_req = 0, tmr_req = 0, call_go = 0, ret_go = 0, bank_bit = 0;
  logic step_go = 0, psw_we = 0;
  logic [2:0] call_page = 0, reg_sel = 0;
  logic [7:0] call_imm = 0, psw_wdata = 0;
  logic [1:0] step_len = 0;
  logic busy, irq_mask, ram_we;
  logic [11:0] pc;
  logic [7:0] psw, reg_addr, ram_addr, ram_wdata, ram_rdata;

  logic [7:0]  mem [256];
  logic [10:0] stk [8];
  logic [11:0] exp_pc;
  logic [7:0]  exp_psw;
  int total = 0, bad = 0, wcnt = 0;
  logic [7:0] wa_prev = 0, wa_last = 0;

  always #4 clk = ~clk;

  ivf_frame_unit u_ivf_frame_unit (
    .clk(clk), .rst_n(rst_n), .ext_req(ext_req), .tmr_req(tmr_req),
    .call_go(call_go), .ret_go(ret_go), .call_page(call_page), .call_imm(call_imm),
    .bank_bit(bank_bit), .step_go(step_go), .step_len(step_len),
    .psw_we(psw_we), .psw_wdata(psw_wdata), .reg_sel(reg_sel),
    .busy(busy), .pc(pc), .psw(psw), .irq_mask(irq_mask), .reg_addr(reg_addr),
    .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
  );

  assign ram_rdata = mem[ram_addr];

  initial for (int i = 0; i < 256; i++) mem[i] = 8'h00;

  always @(posedge clk) begin
    if (ram_we) begin
      mem[ram_addr] <= ram_wdata;
      wcnt    <= wcnt + 1;
      wa_prev <= wa_last;
      wa_last <= ram_addr;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic [7:0] fa(input logic [2:0] sp, input logic hi);
    return 8'd8 + 8'd2 * {5'd0, sp} + {7'd0, hi};
  endfunction

  task automatic psw_write(input logic [7:0] v);
    psw_we = 1; psw_wdata = v;
    @(negedge clk);
    psw_we = 0;
    exp_psw = v;
  endtask

  task automatic op_call(input logic bk, input logic [2:0] pg, input logic [7:0] im);
    logic [10:0] r;
    logic [2:0] sp;
    int wb;
    r = exp_pc[10:0] + 11'd2;
    sp = exp_psw[2:0];
    wb = wcnt;
    bank_bit = bk; call_page = pg; call_imm = im; call_go = 1;
    @(negedge clk);
    call_go = 0;
    check("R12 busy during push", {31'd0, busy}, 1);
    step_go = 1; step_len = 2'd3; psw_we = 1; psw_wdata = 8'h55;
    @(negedge clk);
    step_go = 0; psw_we = 0;
    exp_pc = {bk, pg, im};
    exp_psw[2:0] = sp + 3'd1;
    stk[sp] = r;
    check("R5 call target", {20'd0, pc}, {20'd0, exp_pc});
    check("R4 psw after push", {24'd0, psw}, {24'd0, exp_psw});
    check("R3 frame byte0", {24'd0, mem[fa(sp, 0)]}, {24'd0, r[7:0]});
    check("R3 frame byte1", {24'd0, mem[fa(sp, 1)]}, {24'd0, exp_psw[7:4], 1'b0, r[10:8]});
    check("R2 write count", wcnt - wb, 2);
    check("R2 first addr", {24'd0, wa_prev}, {24'd0, fa(sp, 0)});
    check("R2 second addr", {24'd0, wa_last}, {24'd0, fa(sp, 1)});
  endtask

  task automatic op_ret;
    logic [2:0] sp;
    int wb;
    sp = exp_psw[2:0] - 3'd1;
    wb = wcnt;
    ret_go = 1;
    @(negedge clk);
    ret_go = 0;
    @(negedge clk);
    exp_pc = {exp_pc[11], stk[sp]};
    exp_psw[2:0] = sp;
    check("R11 return pc", {20'd0, pc}, {20'd0, exp_pc});
    check("R11 return psw", {24'd0, psw}, {24'd0, exp_psw});
    check("R11 mask cleared", {31'd0, irq_mask}, 0);
    check("R11 no writes", wcnt - wb, 0);
  endtask

  task automatic op_step(input logic [1:0] n);
    step_go = 1; step_len = n;
    @(negedge clk);
    step_go = 0;
    exp_pc = {exp_pc[11], exp_pc[10:0] + {9'd0, n}};
    check("R9 step", {20'd0, pc}, {20'd0, exp_pc});
  endtask

  // Called at the negedge of the take cycle
  task automatic irq_entry(input logic tmr);
    logic [2:0] sp;
    logic [10:0] saved;
    sp = exp_psw[2:0];
    saved = exp_pc[10:0];
    check("R12 busy on take", {31'd0, busy}, 1);
    step_go = 1; step_len = 2'd1;
    @(negedge clk);
    step_go = 0;
    @(negedge clk);
    exp_pc = {bank_bit, tmr ? 11'd7 : 11'd3};
    exp_psw[2:0] = sp + 3'd1;
    stk[sp] = saved;
    check("R6 vector", {20'd0, pc}, {20'd0, exp_pc});
    check("R7 mask set", {31'd0, irq_mask}, 1);
    check("R8 saved low", {24'd0, mem[fa(sp, 0)]}, {24'd0, saved[7:0]});
    check("R8 saved high", {29'd0, mem[fa(sp, 1)][2:0]}, {29'd0, saved[10:8]});
  endtask

  task automatic pulse(input logic e, input logic t);
    ext_req = e; tmr_req = t;
    @(negedge clk);
    ext_req = 0; tmr_req = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    exp_pc = 0; exp_psw = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 pc reset", {20'd0, pc}, 0);
    check("R1 psw reset", {24'd0, psw}, 0);
    check("R1 mask reset", {31'd0, irq_mask}, 0);
    check("R1 busy reset", {31'd0, busy}, 0);

    // R10 register bank sweep
    for (int b = 0; b < 2; b++) begin
      psw_write({3'd0, b[0], 4'd0});
      for (int s = 0; s < 8; s++) begin
        reg_sel = s[2:0];
        #1;
        check("R10 reg addr", {24'd0, reg_addr}, (b == 1 ? 24 : 0) + s);
      end
    end

    // R9 steps across the bank end
    op_call(1'b1, 3'd7, 8'hFE);
    op_step(2'd1);
    op_step(2'd2);
    op_step(2'd3);
    op_step(2'd0);
    check("R9 bank bit kept", {31'd0, pc[11]}, 1);

    // Calls through SP wrap, then returns through underflow
    psw_write(8'hA8);
    for (int i = 0; i < 8; i++) begin
      op_call(i[0], i[2:0], 8'h13 * i[7:0] + 8'h05);
      psw_write({i[3:0] ^ 4'h5, exp_psw[3:0]});
    end
    check("R4 sp wrapped", {29'd0, psw[2:0]}, 0);
    for (int i = 0; i < 8; i++) op_ret();

    // External alone, then timer while masked
    op_step(2'd3);
    bank_bit = 1'b1;
    pulse(1'b1, 1'b0);
    irq_entry(1'b0);
    pulse(1'b0, 1'b1);
    repeat (3) @(negedge clk);
    check("R7 masked no entry pc", {20'd0, pc}, {20'd0, exp_pc});
    check("R7 masked idle", {31'd0, busy}, 0);
    bank_bit = 1'b0;
    op_ret();
    irq_entry(1'b1);
    op_ret();
    repeat (3) @(negedge clk);
    check("R7 pending cleared", {31'd0, busy}, 0);
    check("R7 pc steady", {20'd0, pc}, {20'd0, exp_pc});

    // Both together: external first
    op_step(2'd2);
    pulse(1'b1, 1'b1);
    irq_entry(1'b0);
    op_ret();
    irq_entry(1'b1);
    op_ret();
    repeat (2) @(negedge clk);
    check("R6 both served", {31'd0, busy}, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule